// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees I2C buses that hang because a target kept SDA low when the controller was reset partway through a read. The target still expects clocks for the rest of its byte. On a start request the block visits each bus in ascending index order. For each bus it releases SDA, lets the level settle through a two-flop synchroniser, and samples it. A high level means the bus is free, and the block moves to the next bus without touching SCL.

A low level starts the fixed recovery pattern. SCL is released high for a long settling time. Nine SCL pulses follow while SDA stays released. Next comes one extra clock with SDA released, which the target reads as a NAK. Last comes a STOP: SDA is pulled low while SCL is low, SCL is released, then SDA is released. After the STOP the block samples SDA again. If it is still low, the bus's bit in a failure mask is set. When every bus has been visited, a one-cycle done pulse is issued.

Both pad outputs are open-drain enables: a 1 pulls the line low and a 0 releases it to the pull-up. A programmable divider sets the half-period in system clocks. A parameter sets the settling time as a number of half-periods.

Top module: `i2c_bus_recover`

## Requirements
- R1: A bus whose synchronised SDA reads high after the probe is skipped: its SCL and SDA enables stay 0 and its failure bit stays 0.
- R2: On a bus found low, SCL stays released for at least SETTLE_HALVES half-periods before its first falling edge.
- R3: A stuck bus then sees nine SCL pulses. Each low phase and each following high phase lasts exactly one half-period, and SDA is released throughout.
- R4: After the ninth falling edge, SCL stays low for one half-period plus max(1, H/5) system clocks, where H is the half-period. SDA is released during that time. SCL is then released for one half-period. A target that has released SDA therefore sees SDA high at this rising edge, which is the NAK.
- R5: After the NAK clock, SCL is held low for two half-periods. SDA is driven low during the second of them, so SDA is low when SCL next rises.
- R6: While SCL is high, SDA is released from low to high, forming exactly one STOP condition. This is the only SDA rise during high SCL on a recovered bus.
- R7: After the STOP, the bus is sampled again. fail_mask bit b is set to 1 exactly when bus b's SDA is still low.
- R8: Buses are handled one at a time in ascending index order. At most one bus has any enable set at any time. The failures are collected one bit per bus in fail_mask, and fail is the OR of fail_mask.
- R9: done is high for exactly one cycle at the end of each accepted sequence. fail_mask clears when a start is accepted and then holds until the next accepted start.
- R10: A start request while busy is high is ignored. The running sequence, its recorded failure bits and its single done pulse are unaffected.
- R11: A synchronous active-high reset returns the block to idle (busy=0) with all SCL and SDA enables at 0 by the next clock.
- R12: The half-period is half_div+1 system clocks, captured when a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a recovery pass over all buses |
| half_div | input | DIV_W | Half-period minus one, in system clocks |
| sda_in | input | NUM_BUS | Raw SDA line levels, one per bus |
| scl_oe | output | NUM_BUS | Pull SCL low, one per bus |
| sda_oe | output | NUM_BUS | Pull SDA low, one per bus |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at end of sequence |
| fail | output | 1 | At least one bus still stuck |
| fail_mask | output | NUM_BUS | Per-bus still-stuck flags |

## Verification
Two events can coincide: a new start request can arrive in the same cycle that the sequencer records a bus's failure bit or moves on to the next bus. This is provoked by putting a permanently stuck target on bus 0 and issuing a start as soon as that bus's fail_mask bit appears, while the remaining buses are still being handled. The run is judged at the pins: the bit must survive, each later bus must still receive its complete pulse pattern in order, and done must pulse only once. Random target behaviour (free, releasing after 1 to 9 clocks, or never releasing) and random half-periods are checked against pulse timings computed by the bench.

// File: rtl/i2c_rec_pkg.sv
package i2c_rec_pkg;

    localparam int unsigned DUMMY_PULSES = 9;
    localparam int unsigned SYNC_STAGES  = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROBE,
        ST_SETTLE,
        ST_PHI,
        ST_PLO,
        ST_NAK_SU,
        ST_NAK_HI,
        ST_NAK_LO,
        ST_STP_LO,
        ST_STP_RISE,
        ST_STP_HOLD,
        ST_VERIFY,
        ST_NEXT,
        ST_FIN
    } rec_state_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } pad_drive_t;

    function automatic pad_drive_t drive_of(rec_state_e s);
        pad_drive_t d;
        d.scl_low = (s == ST_PLO) || (s == ST_NAK_SU) || (s == ST_NAK_LO) || (s == ST_STP_LO);
        d.sda_low = (s == ST_STP_LO) || (s == ST_STP_RISE);
        return d;
    endfunction

    function automatic logic is_timed(rec_state_e s);
        return !((s == ST_IDLE) || (s == ST_NEXT) || (s == ST_FIN));
    endfunction

endpackage

// File: rtl/i2c_rec_sync.sv
module i2c_rec_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '1;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_rec_timer.sv
module i2c_rec_timer #(
    parameter int unsigned W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         expire
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (load)          cnt <= len - W'(1);
        else if (cnt != '0)     cnt <= cnt - W'(1);
    end

    assign expire = (cnt == '0);

    // R12: every phase lasts at least one clock
    assert_len_nonzero_R12: assert property (@(posedge clk) disable iff (rst)
        load |-> (len != '0));
endmodule

// File: rtl/i2c_rec_seq.sv
module i2c_rec_seq
    import i2c_rec_pkg::*;
#(
    parameter int unsigned NB            = 3,
    parameter int unsigned DIV_W         = 8,
    parameter int unsigned SETTLE_HALVES = 2000
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [DIV_W-1:0]             half_div,
    input  logic [NB-1:0]                sda_s,
    output logic [((NB>1)?$clog2(NB):1)-1:0] idx,
    output pad_drive_t                   drv,
    output logic                         busy,
    output logic                         done,
    output logic [NB-1:0]                fail_mask
);
    localparam int unsigned CNT_W   = DIV_W + 1;
    localparam int unsigned IDX_W   = (NB > 1) ? $clog2(NB) : 1;
    localparam int unsigned REP_MAX = (SETTLE_HALVES > DUMMY_PULSES) ? SETTLE_HALVES : DUMMY_PULSES;
    localparam int unsigned REP_W   = $clog2(REP_MAX + 1);
    localparam logic [CNT_W-1:0] PROBE_LEN = CNT_W'(SYNC_STAGES + 1);

    rec_state_e       st, nxt;
    logic [REP_W-1:0] rep;
    logic [CNT_W-1:0] half_q, fifth_q, ld_len, new_half, new_fifth;
    logic             ld, tmr_exp, cur_sda;

    i2c_rec_timer #(.W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(ld), .len(ld_len), .expire(tmr_exp)
    );

    assign cur_sda   = sda_s[idx];
    assign new_half  = CNT_W'(half_div) + CNT_W'(1);
    assign new_fifth = ((new_half / CNT_W'(5)) == '0) ? CNT_W'(1) : (new_half / CNT_W'(5));

    always_comb begin
        nxt    = st;
        ld     = 1'b0;
        ld_len = half_q;
        case (st)
            ST_IDLE: if (start) begin
                nxt = ST_PROBE; ld = 1'b1; ld_len = PROBE_LEN;
            end
            ST_PROBE: if (tmr_exp) begin
                if (cur_sda) nxt = ST_NEXT;
                else begin nxt = ST_SETTLE; ld = 1'b1; end
            end
            ST_SETTLE: if (tmr_exp) begin
                ld = 1'b1;
                if (rep == REP_W'(SETTLE_HALVES - 1)) nxt = ST_PHI;
            end
            ST_PHI: if (tmr_exp) begin nxt = ST_PLO; ld = 1'b1; end
            ST_PLO: if (tmr_exp) begin
                ld = 1'b1;
                if (rep == REP_W'(DUMMY_PULSES - 1)) begin
                    nxt = ST_NAK_SU; ld_len = fifth_q;
                end else nxt = ST_PHI;
            end
            ST_NAK_SU:   if (tmr_exp) begin nxt = ST_NAK_HI;   ld = 1'b1; end
            ST_NAK_HI:   if (tmr_exp) begin nxt = ST_NAK_LO;   ld = 1'b1; end
            ST_NAK_LO:   if (tmr_exp) begin nxt = ST_STP_LO;   ld = 1'b1; end
            ST_STP_LO:   if (tmr_exp) begin nxt = ST_STP_RISE; ld = 1'b1; end
            ST_STP_RISE: if (tmr_exp) begin nxt = ST_STP_HOLD; ld = 1'b1; end
            ST_STP_HOLD: if (tmr_exp) begin
                nxt = ST_VERIFY; ld = 1'b1; ld_len = PROBE_LEN;
            end
            ST_VERIFY: if (tmr_exp) nxt = ST_NEXT;
            ST_NEXT: begin
                if (idx == IDX_W'(NB - 1)) nxt = ST_FIN;
                else begin nxt = ST_PROBE; ld = 1'b1; ld_len = PROBE_LEN; end
            end
            ST_FIN:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            rep       <= '0;
            idx       <= '0;
            fail_mask <= '0;
            half_q    <= CNT_W'(1);
            fifth_q   <= CNT_W'(1);
        end else begin
            st <= nxt;
            case (st)
                ST_IDLE: if (start) begin
                    idx       <= '0;
                    fail_mask <= '0;
                    half_q    <= new_half;
                    fifth_q   <= new_fifth;
                end
                ST_PROBE:  if (tmr_exp) rep <= '0;
                ST_SETTLE: if (tmr_exp)
                    rep <= (rep == REP_W'(SETTLE_HALVES - 1)) ? '0 : rep + REP_W'(1);
                ST_PLO:    if (tmr_exp) rep <= rep + REP_W'(1);
                ST_VERIFY: if (tmr_exp) fail_mask[idx] <= ~cur_sda;
                ST_NEXT:   if (idx != IDX_W'(NB - 1)) idx <= idx + IDX_W'(1);
                default: ;
            endcase
        end
    end

    assign drv  = drive_of(st);
    assign busy = (st != ST_IDLE);
    assign done = (st == ST_FIN);

    // R9: done never lasts two cycles
    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: result held while idle without a request
    assert_mask_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !start) |=> $stable(fail_mask));

    // R10: a request during a running pass does not end or restart it
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && start) |=> busy);

    // R12: a timed phase only advances once its timer runs out
    assert_phase_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (is_timed(st) && !tmr_exp) |=> (st == $past(st)));

    // R11: reset leaves the block idle with lines released
    assert_reset_idle_R11: assert property (@(posedge clk)
        rst |=> (!busy && !drv.scl_low && !drv.sda_low));
endmodule

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover
    import i2c_rec_pkg::*;
#(
    parameter int unsigned NUM_BUS       = 3,
    parameter int unsigned DIV_W         = 8,
    parameter int unsigned SETTLE_HALVES = 2000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [DIV_W-1:0]   half_div,
    input  logic [NUM_BUS-1:0] sda_in,
    output logic [NUM_BUS-1:0] scl_oe,
    output logic [NUM_BUS-1:0] sda_oe,
    output logic               busy,
    output logic               done,
    output logic               fail,
    output logic [NUM_BUS-1:0] fail_mask
);
    localparam int unsigned IDX_W = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1;

    logic [NUM_BUS-1:0] sda_s;
    logic [IDX_W-1:0]   idx;
    pad_drive_t         drv;

    i2c_rec_sync #(.W(NUM_BUS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(sda_in), .q(sda_s)
    );

    i2c_rec_seq #(.NB(NUM_BUS), .DIV_W(DIV_W), .SETTLE_HALVES(SETTLE_HALVES)) u_seq (
        .clk(clk), .rst(rst), .start(start), .half_div(half_div), .sda_s(sda_s),
        .idx(idx), .drv(drv), .busy(busy), .done(done), .fail_mask(fail_mask)
    );

    generate
        for (genvar g = 0; g < NUM_BUS; g++) begin : g_pad
            assign scl_oe[g] = (idx == IDX_W'(g)) && drv.scl_low;
            assign sda_oe[g] = (idx == IDX_W'(g)) && drv.sda_low;
        end
    endgenerate

    assign fail = |fail_mask;

    // R8: never more than one bus driven
    assert_one_bus_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(scl_oe | sda_oe));
endmodule

// File: tb/i2c_bus_recover_tb_top.sv
module i2c_bus_recover_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 3;
    localparam int DIV_W = 8;
    localparam int SET_H = 20;
    localparam int WDOG = 190000;

    logic clk = 1'b0;
    logic rst, start;
    logic [DIV_W-1:0] half_div;
    logic [NB-1:0] sda_in, scl_oe, sda_oe, fail_mask, scl_ln, sda_ln, tpull;
    logic busy, done, fail;

    int checks = 0, fails = 0, cyc = 0;
    int mode[NB], rel[NB];
    int nf[NB], nr[NB], stops[NB], ndone;
    int fall_t[NB][16], rise_t[NB][16];
    logic sda_r[NB][16];
    logic prev_scl[NB], prev_sda[NB];
    logic clr = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_bus_recover #(.NUM_BUS(NB), .DIV_W(DIV_W), .SETTLE_HALVES(SET_H)) dut_i (
        .clk(clk), .rst(rst), .start(start), .half_div(half_div), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done), .fail(fail),
        .fail_mask(fail_mask)
    );

    always_comb begin
        for (int b = 0; b < NB; b++)
            tpull[b] = (mode[b] == 2) || (mode[b] == 1 && nf[b] < rel[b]);
    end
    assign scl_ln = ~scl_oe;
    assign sda_ln = ~sda_oe & ~tpull;
    assign sda_in = sda_ln;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG) begin
            fails++;
            $display("FAIL R9 watchdog: done not seen, actual busy=%0b expected 0", busy);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (clr) begin
            ndone = 0;
            for (int b = 0; b < NB; b++) begin
                nf[b] = 0; nr[b] = 0; stops[b] = 0;
                prev_scl[b] = 1'b1; prev_sda[b] = 1'b1;
            end
        end else begin
            if (done) ndone++;
            for (int b = 0; b < NB; b++) begin
                if (prev_scl[b] && !scl_ln[b] && nf[b] < 16) begin
                    fall_t[b][nf[b]] = cyc; nf[b]++;
                end
                if (!prev_scl[b] && scl_ln[b] && nr[b] < 16) begin
                    rise_t[b][nr[b]] = cyc; sda_r[b][nr[b]] = sda_ln[b]; nr[b]++;
                end
                if (prev_scl[b] && scl_ln[b] && !prev_sda[b] && sda_ln[b]) stops[b]++;
                prev_scl[b] = scl_ln[b];
                prev_sda[b] = sda_ln[b];
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wneg();
        @(negedge clk); #1;
    endtask

    function automatic logic [NB-1:0] exp_mask();
        logic [NB-1:0] m;
        for (int b = 0; b < NB; b++) m[b] = (mode[b] == 2);
        return m;
    endfunction

    task automatic launch(input int hd, input int m0, input int m1, input int m2,
                          input int r0, input int r1, input int r2, output int t0);
        mode[0] = m0; mode[1] = m1; mode[2] = m2;
        rel[0] = r0; rel[1] = r1; rel[2] = r2;
        half_div = DIV_W'(hd);
        clr = 1'b1; wneg(); wneg(); clr = 1'b0;
        start = 1'b1; wneg(); start = 1'b0;
        t0 = cyc;
        chk(busy == 1'b1 && fail_mask == '0, "R9 mask cleared on start", int'(fail_mask), 0);
    endtask

    task automatic wait_done();
        int n = 0;
        while (ndone == 0 && n < 30000) begin wneg(); n++; end
    endtask

    task automatic judge(input int hd, input int t0);
        int h = hd + 1;
        int f = (h / 5 < 1) ? 1 : h / 5;
        int last_end = t0;
        int bad;
        logic [NB-1:0] em = exp_mask();
        wneg(); wneg();
        chk(ndone == 1, "R9 single done pulse", ndone, 1);
        chk(fail_mask == em, "R7 fail mask", int'(fail_mask), int'(em));
        chk(fail == |em, "R8 fail is OR of mask", int'(fail), int'(|em));
        for (int b = 0; b < NB; b++) begin
            if (mode[b] == 0) begin
                chk(nf[b] == 0 && nr[b] == 0, "R1 free bus left untouched", nf[b], 0);
            end else begin
                chk(nf[b] == 10 && nr[b] == 10, "R3 pulse count", nf[b], 10);
                if (nf[b] == 10 && nr[b] == 10) begin
                    chk(fall_t[b][0] > last_end, "R8 bus order", fall_t[b][0], last_end + 1);
                    chk(fall_t[b][0] - t0 >= SET_H * h, "R2 settle time",
                        fall_t[b][0] - t0, SET_H * h);
                    bad = 0;
                    for (int k = 0; k < 8; k++) begin
                        if (rise_t[b][k] - fall_t[b][k] != h) bad++;
                        if (fall_t[b][k+1] - rise_t[b][k] != h) bad++;
                    end
                    chk(bad == 0, "R3 R12 pulse widths", bad, 0);
                    chk(rise_t[b][8] - fall_t[b][8] == h + f, "R4 NAK setup low",
                        rise_t[b][8] - fall_t[b][8], h + f);
                    chk(fall_t[b][9] - rise_t[b][8] == h, "R4 NAK high",
                        fall_t[b][9] - rise_t[b][8], h);
                    chk(sda_r[b][8] == (mode[b] == 1), "R4 SDA at NAK rise",
                        int'(sda_r[b][8]), int'(mode[b] == 1));
                    chk(rise_t[b][9] - fall_t[b][9] == 2 * h, "R5 low before STOP",
                        rise_t[b][9] - fall_t[b][9], 2 * h);
                    chk(sda_r[b][9] == 1'b0, "R5 SDA low at STOP rise", int'(sda_r[b][9]), 0);
                    chk(stops[b] == int'(mode[b] == 1), "R6 STOP count",
                        stops[b], int'(mode[b] == 1));
                    last_end = rise_t[b][9];
                end
            end
        end
        repeat (8) wneg();
        chk(fail_mask == em && !busy, "R9 mask held when idle", int'(fail_mask), int'(em));
    endtask

    initial begin
        int t0, hd;
        int m[NB], r[NB];
        void'($urandom(32'd4242));
        rst = 1'b1; start = 1'b0; half_div = '0;
        for (int b = 0; b < NB; b++) begin mode[b] = 0; rel[b] = 1; end
        wneg(); wneg();
        chk(scl_oe == '0 && sda_oe == '0 && !busy && !done, "R11 reset state",
            int'({scl_oe, sda_oe}), 0);
        rst = 1'b0; wneg();

        launch(3, 0, 0, 0, 1, 1, 1, t0); wait_done(); judge(3, t0);
        launch(4, 1, 0, 0, 9, 1, 1, t0); wait_done(); judge(4, t0);
        launch(9, 0, 2, 0, 1, 1, 1, t0); wait_done(); judge(9, t0);
        launch(0, 0, 0, 1, 1, 1, 1, t0); wait_done(); judge(0, t0);

        // R10: request lands right when bus 0 failure is recorded
        launch(1, 2, 1, 1, 1, 5, 9, t0);
        while (fail_mask[0] == 1'b0 && ndone == 0) wneg();
        start = 1'b1; wneg(); start = 1'b0;
        chk(fail_mask[0] == 1'b1 && busy, "R10 start while busy ignored",
            int'(fail_mask[0]), 1);
        wait_done(); judge(1, t0);

        for (int t = 0; t < 8; t++) begin
            hd = int'($urandom_range(0, 11));
            for (int b = 0; b < NB; b++) begin
                m[b] = int'($urandom_range(0, 2));
                r[b] = int'($urandom_range(1, 9));
            end
            launch(hd, m[0], m[1], m[2], r[0], r[1], r[2], t0);
            wait_done(); judge(hd, t0);
        end

        // R11: reset in the middle of clocking
        launch(2, 2, 2, 2, 1, 1, 1, t0);
        while (nf[0] < 4) wneg();
        rst = 1'b1; wneg();
        chk(scl_oe == '0 && sda_oe == '0 && !busy, "R11 reset mid-run",
            int'({scl_oe, sda_oe}), 0);
        rst = 1'b0; wneg();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule